// File: doc/BRIEF.md
# Line-Locked Pixel Clock Enable Generator

This block produces a pixel-rate enable strobe from a fast system clock and keeps it phase- and frequency-locked to an incoming horizontal sync. Its target is a fixed number of pixels in each line, set by a line-duration code. A numerically controlled oscillator (NCO) issues the strobe. It holds an 8.8 fixed-point pixel period, counted in system-clock cycles.

At each rising sync edge, the block compares the pixels counted over the previous line with the target. From the signed difference it corrects both the period (the frequency term) and the oscillator phase (a one-shot phase term). Each correction is scaled down by its own 3-bit right-shift constant.

A configuration strobe captures the line-duration code, the shift constants and an initial integer period. The same strobe reloads the oscillator, which lets the loop start close to the new rate after a mode change. The block reports lock and can suppress the colour and blanking outputs while it is unlocked.

Top module: `linePixelPll`

## Requirements
- R1: Out of reset, and after every configuration load, the NCO period equals the initial-period value in whole system-clock cycles. The reset default is 6. `pixEn` then pulses exactly once every that many cycles until a sync edge is evaluated.
- R2: An initial-period value of 0 is treated as one cycle, so `pixEn` is high on every cycle.
- R3: The target pixel count per line is 12·(2·LD+1), where LD is the 6-bit line-duration code (reset default 0). Once the block is locked on a line whose length is an exact multiple of the period, every line contains exactly that many `pixEn` pulses.
- R4: The first sync rising edge after a load or reset only starts the pixel count. Each later edge evaluates err = pixels counted minus target. `locked` rises on the eighth consecutive evaluated line with |err| ≤ 1, which is the ninth edge, and not before it.
- R5: A single evaluated line with |err| > 4 leaves `locked` set. A second such line in a row clears it.
- R6: With the period preset one cycle short of the true line rate, the frequency correction (err·256 shifted right by the frequency constant) and the phase correction (err·256 shifted right by the phase constant, subtracted from the phase) bring the loop to lock within 40 lines. After lock, each line holds the target count ±1.
- R7: A configuration load clears `locked` on the following cycle and restarts the NCO from the newly loaded period.
- R8: While `lockEn` is 1 and `locked` is 0, `rgbOut` and `blankOut` are forced to 0. Otherwise they equal `rgbIn` and `blankIn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, asynchronous; the rising edge marks a line start |
| cfgLoad | input | 1 | One-cycle strobe that captures the configuration and restarts the loop |
| cfgLineDur | input | 6 | Line-duration code LD |
| cfgInitPer | input | 8 | Initial pixel period in whole clock cycles |
| cfgPhaseSh | input | 3 | Right-shift constant for the phase correction |
| cfgFreqSh | input | 3 | Right-shift constant for the frequency correction |
| lockEn | input | 1 | 1 = suppress the video outputs while unlocked |
| rgbIn | input | 3 | Colour inputs |
| blankIn | input | 1 | Fast-blank input |
| pixEn | output | 1 | Pixel-rate enable strobe |
| locked | output | 1 | Loop lock flag |
| rgbOut | output | 3 | Gated colour outputs |
| blankOut | output | 1 | Gated fast-blank output |

## Verification
The hardest state to reach from the ports is a drop of lock. It needs two consecutive lines with a large count error, and the loop is busy correcting its period in between. The stimulus first reaches exact lock with a line length equal to target times period, which gives a zero error on every line. It then doubles the line length. The first long line misses by 12 pixels. The gain of the reset-default frequency constant is small enough that the second long line still misses by more than 4, so the single-line and two-line cases fall on known lines. Lock timing itself is swept over several line-duration codes and integer periods. In each case the ninth edge is the first at which lock may appear.

// File: rtl/linePllPkg.sv
package linePllPkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic cfgLoad;   // capture configuration, restart NCO
    logic lineEdge;  // synchronized hsync rising edge
    logic lineEval;  // edge on which the error is applied
  } ctrlStrb_t;
endpackage

// File: rtl/pllDatapath.sv
module pllDatapath
  import linePllPkg::*;
#(
  parameter int LD_W    = 6,
  parameter int PP_W    = 8,
  parameter int FRAC_W  = 8,
  parameter int SH_W    = 3,
  parameter int CNT_W   = 12,
  parameter int GROUP   = 12,
  parameter int TOL_IN  = 1,
  parameter int TOL_OUT = 4,
  parameter int RST_LD  = 0,
  parameter int RST_PP  = 6,
  parameter int RST_PSH = 4,
  parameter int RST_FSH = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  input  logic [LD_W-1:0] cfgLineDur,
  input  logic [PP_W-1:0] cfgInitPer,
  input  logic [SH_W-1:0] cfgPhaseSh,
  input  logic [SH_W-1:0] cfgFreqSh,
  output logic            pixEn,
  output logic            errSmall,
  output logic            errLarge
);
  localparam int PER_W  = PP_W + FRAC_W;
  localparam int ONE    = 1 << FRAC_W;
  localparam int WIDE_W = CNT_W + FRAC_W + 4;
  localparam logic signed [WIDE_W-1:0] ONE_W = WIDE_W'(ONE);
  localparam logic signed [WIDE_W-1:0] MAX_W = WIDE_W'((1 << PER_W) - 1);

  logic [LD_W-1:0]  ldReg;
  logic [SH_W-1:0]  phShReg, frShReg;
  logic [PER_W-1:0] period, phase, loadPer, advPhase, newPer, newPh;
  logic [PER_W:0]   phSumAdv;
  logic [CNT_W-1:0] pixCount, mTarget;
  logic signed [CNT_W:0]    err;
  logic signed [WIDE_W-1:0] errWide, errScaled, freqDelta, phaseDelta;
  logic signed [WIDE_W-1:0] perSum, phSum, newPerW;

  // target pixels per line
  assign mTarget = CNT_W'(GROUP) * ((CNT_W'(ldReg) << 1) + CNT_W'(1));

  // period preload, a zero value is floored to one clock
  assign loadPer = (cfgInitPer == '0) ? PER_W'(ONE) : {cfgInitPer, {FRAC_W{1'b0}}};

  // NCO: one clock worth of phase per cycle, wrap gives a pixel
  assign phSumAdv = {1'b0, phase} + (PER_W+1)'(ONE);
  assign pixEn    = (phSumAdv >= {1'b0, period});
  assign advPhase = pixEn ? PER_W'(phSumAdv - {1'b0, period}) : PER_W'(phSumAdv);

  // per-line error and loop filter
  assign err        = $signed({1'b0, pixCount}) - $signed({1'b0, mTarget});
  assign errWide    = WIDE_W'(err);
  assign errScaled  = errWide <<< FRAC_W;
  assign freqDelta  = errScaled >>> frShReg;
  assign phaseDelta = errScaled >>> phShReg;
  assign errSmall   = (err >= -(CNT_W+1)'(TOL_IN)) && (err <= (CNT_W+1)'(TOL_IN));
  assign errLarge   = (err > (CNT_W+1)'(TOL_OUT)) || (err < -(CNT_W+1)'(TOL_OUT));

  always_comb begin
    perSum = $signed(WIDE_W'(period)) + freqDelta;
    if (perSum < ONE_W)      newPerW = ONE_W;
    else if (perSum > MAX_W) newPerW = MAX_W;
    else                     newPerW = perSum;
    newPer = PER_W'(newPerW);
    phSum  = $signed(WIDE_W'(advPhase)) - phaseDelta;
    if (phSum < 0)             newPh = '0;
    else if (phSum >= newPerW) newPh = PER_W'(newPerW - 1);
    else                       newPh = PER_W'(phSum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldReg    <= LD_W'(RST_LD);
      phShReg  <= SH_W'(RST_PSH);
      frShReg  <= SH_W'(RST_FSH);
      period   <= {PP_W'(RST_PP), {FRAC_W{1'b0}}};
      phase    <= '0;
      pixCount <= '0;
    end else if (strb.cfgLoad) begin
      ldReg    <= cfgLineDur;
      phShReg  <= cfgPhaseSh;
      frShReg  <= cfgFreqSh;
      period   <= loadPer;
      phase    <= '0;
      pixCount <= '0;
    end else begin
      if (strb.lineEval) begin
        period <= newPer;
        phase  <= newPh;
      end else begin
        phase  <= advPhase;
      end
      if (strb.lineEdge)                pixCount <= pixEn ? CNT_W'(1) : '0;
      else if (pixEn && !(&pixCount))   pixCount <= pixCount + 1'b1;
    end
  end

  // R2
  period_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    period >= PER_W'(ONE));
  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase < period);
  // R7
  load_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgLoad |=> (phase == '0) && (pixCount == '0));
endmodule

// File: rtl/pllControl.sv
module pllControl
  import linePllPkg::*;
#(
  parameter int LOCK_LINES   = 8,
  parameter int UNLOCK_LINES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hsync,
  input  logic      cfgLoad,
  input  logic      errSmall,
  input  logic      errLarge,
  output ctrlStrb_t strb,
  output logic      locked
);
  localparam int GC_W = $clog2(LOCK_LINES + 1);
  localparam int BC_W = $clog2(UNLOCK_LINES + 1);

  logic [2:0]      syncQ;
  logic            armed;
  logic [GC_W-1:0] goodCnt;
  logic [BC_W-1:0] badCnt;

  assign strb.cfgLoad  = cfgLoad;
  assign strb.lineEdge = syncQ[1] & ~syncQ[2];
  assign strb.lineEval = strb.lineEdge & armed & ~cfgLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], hsync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0; goodCnt <= '0; badCnt <= '0; locked <= 1'b0;
    end else if (cfgLoad) begin
      armed <= 1'b0; goodCnt <= '0; badCnt <= '0; locked <= 1'b0;
    end else begin
      if (strb.lineEdge) armed <= 1'b1;
      if (strb.lineEval) begin
        if (errSmall) begin
          badCnt <= '0;
          if (goodCnt != GC_W'(LOCK_LINES)) goodCnt <= goodCnt + 1'b1;
          if (goodCnt == GC_W'(LOCK_LINES - 1)) locked <= 1'b1;
        end else if (errLarge) begin
          goodCnt <= '0;
          if (badCnt != BC_W'(UNLOCK_LINES)) badCnt <= badCnt + 1'b1;
          if (badCnt == BC_W'(UNLOCK_LINES - 1)) locked <= 1'b0;
        end else begin
          goodCnt <= '0;
          badCnt  <= '0;
        end
      end
    end
  end

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(strb.lineEval));
  // R4
  good_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    goodCnt <= GC_W'(LOCK_LINES));
  // R5
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(strb.lineEval) || $past(cfgLoad)));
  // R7
  load_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !locked);
endmodule

// File: rtl/linePixelPll.sv
module linePixelPll
  import linePllPkg::*;
#(
  parameter int LD_W = 6,
  parameter int PP_W = 8,
  parameter int SH_W = 3,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hsync,
  input  logic            cfgLoad,
  input  logic [LD_W-1:0] cfgLineDur,
  input  logic [PP_W-1:0] cfgInitPer,
  input  logic [SH_W-1:0] cfgPhaseSh,
  input  logic [SH_W-1:0] cfgFreqSh,
  input  logic            lockEn,
  input  logic [CW-1:0]   rgbIn,
  input  logic            blankIn,
  output logic            pixEn,
  output logic            locked,
  output logic [CW-1:0]   rgbOut,
  output logic            blankOut
);
  ctrlStrb_t strb;
  logic errSmall, errLarge, gateOn;

  pllControl u_ctrl (
    .clk(clk), .rstN(rstN), .hsync(hsync), .cfgLoad(cfgLoad),
    .errSmall(errSmall), .errLarge(errLarge), .strb(strb), .locked(locked)
  );

  pllDatapath #(.LD_W(LD_W), .PP_W(PP_W), .SH_W(SH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgLineDur(cfgLineDur),
    .cfgInitPer(cfgInitPer), .cfgPhaseSh(cfgPhaseSh), .cfgFreqSh(cfgFreqSh),
    .pixEn(pixEn), .errSmall(errSmall), .errLarge(errLarge)
  );

  assign gateOn   = lockEn & ~locked;
  assign rgbOut   = gateOn ? '0 : rgbIn;
  assign blankOut = gateOn ? 1'b0 : blankIn;
endmodule

// File: tb/linePixelPll_tb.sv
`timescale 1ns/1ps
module linePixelPll_tb_top;
  logic clk = 1'b0, rstN = 1'b0, hsync = 1'b0, cfgLoad = 1'b0;
  logic [5:0] cfgLineDur = '0;
  logic [7:0] cfgInitPer = 8'd6;
  logic [2:0] cfgPhaseSh = 3'd4, cfgFreqSh = 3'd4;
  logic lockEn = 1'b1, blankIn = 1'b1;
  logic [2:0] rgbIn = 3'b101;
  logic pixEn, locked, blankOut;
  logic [2:0] rgbOut;
  int nChk = 0, nErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  linePixelPll dut_i (
    .clk(clk), .rstN(rstN), .hsync(hsync), .cfgLoad(cfgLoad),
    .cfgLineDur(cfgLineDur), .cfgInitPer(cfgInitPer), .cfgPhaseSh(cfgPhaseSh),
    .cfgFreqSh(cfgFreqSh), .lockEn(lockEn), .rgbIn(rgbIn), .blankIn(blankIn),
    .pixEn(pixEn), .locked(locked), .rgbOut(rgbOut), .blankOut(blankOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doLoad(input int ld, input int pp, input int ph, input int fr);
    @(negedge clk);
    cfgLineDur = 6'(ld); cfgInitPer = 8'(pp);
    cfgPhaseSh = 3'(ph); cfgFreqSh = 3'(fr);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    check(locked == 1'b0, "R7 lock cleared by load", int'(locked), 0);
  endtask

  task automatic measureGap(output int gap);
    int w = 0;
    gap = 0;
    while (w < 1000) begin
      @(negedge clk);
      if (pixEn) break;
      w++;
    end
    while (gap < 1000) begin
      @(negedge clk);
      gap++;
      if (pixEn) break;
    end
  endtask

  // one line: hsync high for 4 cycles, pixel count over exactly len cycles
  task automatic runLine(input int len, output int cnt, output bit lockMid,
                         output int rgbMid, output int blankMid);
    cnt = 0; lockMid = 0; rgbMid = 0; blankMid = 0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (pixEn) cnt++;
      if (c == 10) begin
        lockMid = locked; rgbMid = int'(rgbOut); blankMid = int'(blankOut);
      end
      hsync = (c < 4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    int gap, cnt, rgbM, blkM, m, len, lockLine;
    bit lk;
    int pps[3] = '{2, 3, 5};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(locked == 1'b0, "R4 reset unlocked", int'(locked), 0);
    check(rgbOut == 3'b000 && blankOut == 1'b0, "R8 gated while unlocked",
          int'({rgbOut, blankOut}), 0);
    measureGap(gap);
    check(gap == 6, "R1 reset period", gap, 6);
    measureGap(gap);
    check(gap == 6, "R1 reset period repeat", gap, 6);
    lockEn = 1'b0;
    @(negedge clk);
    check(rgbOut == 3'b101 && blankOut == 1'b1, "R8 pass with lockEn 0",
          int'({rgbOut, blankOut}), 11);
    lockEn = 1'b1;

    // sweep line-duration codes and integer periods
    for (int ld = 0; ld < 3; ld++) begin
      for (int pi = 0; pi < 3; pi++) begin
        m = 12 * (2 * ld + 1);
        len = m * pps[pi];
        doLoad(ld, pps[pi], 4, 4);
        measureGap(gap);
        check(gap == pps[pi], "R1 loaded period", gap, pps[pi]);
        for (int ln = 1; ln <= 11; ln++) begin
          runLine(len, cnt, lk, rgbM, blkM);
          if (ln == 8) begin
            check(lk == 1'b0, "R4 no lock before ninth edge", int'(lk), 0);
            check(rgbM == 0 && blkM == 0, "R8 gated before lock", rgbM, 0);
          end
          if (ln == 9) begin
            check(lk == 1'b1, "R4 lock at ninth edge", int'(lk), 1);
            check(rgbM == 5 && blkM == 1, "R8 pass when locked", rgbM, 5);
          end
          if (ln >= 10) check(cnt == m, "R3 pixels per line", cnt, m);
        end
      end
    end

    // reload while locked
    doLoad(0, 4, 4, 4);
    measureGap(gap);
    check(gap == 4, "R7 restart with new period", gap, 4);

    // zero period floors to one clock
    doLoad(0, 0, 4, 4);
    measureGap(gap);
    check(gap == 1, "R2 zero period floor", gap, 1);
    measureGap(gap);
    check(gap == 1, "R2 zero period floor repeat", gap, 1);

    // lock then two long lines
    doLoad(0, 6, 4, 4);
    for (int ln = 1; ln <= 10; ln++) runLine(72, cnt, lk, rgbM, blkM);
    check(lk == 1'b1, "R5 locked before disturbance", int'(lk), 1);
    runLine(144, cnt, lk, rgbM, blkM);
    check(lk == 1'b1, "R5 still locked", int'(lk), 1);
    runLine(144, cnt, lk, rgbM, blkM);
    check(lk == 1'b1, "R5 one bad line keeps lock", int'(lk), 1);
    runLine(144, cnt, lk, rgbM, blkM);
    check(lk == 1'b0, "R5 two bad lines drop lock", int'(lk), 0);

    // pull-in from a short preset
    doLoad(0, 5, 2, 2);
    lockLine = 0;
    for (int ln = 1; ln <= 40; ln++) begin
      runLine(72, cnt, lk, rgbM, blkM);
      if (lk && lockLine == 0) lockLine = ln;
    end
    check(lockLine != 0, "R6 pull-in reaches lock", lockLine, 1);
    for (int ln = 0; ln < 3; ln++) begin
      runLine(72, cnt, lk, rgbM, blkM);
      check(cnt >= 11 && cnt <= 13, "R6 count within one pixel", cnt, 12);
      check(lk == 1'b1, "R6 lock held", int'(lk), 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule